// File: doc/BRIEF.md
# Radio Link Statistics Collector

This block sits on the radio side of a host link and keeps track of how well the air link is doing. It watches the outcome strobes that the medium access controller raises at the end of each transmission request. It also reads the current output-queue occupancy and receives a completion-time measurement for every packet that finishes. A host asks for these numbers by sending a single statistics-request byte over a byte stream. The block answers with a fixed five-byte response.

Failures are counted over windows of 255 requests. Two abort conditions each count as a failure: the channel is still busy when the access attempt limit runs out, and the retransmission limit is reached. When a window closes, its failure total is latched for reporting and a fresh window starts. Completion times are smoothed with an exponential moving average that uses a weight of one eighth for each new sample.

The leading byte of every host-link message gives its type. The codes are 0x01 for configuration, 0x02 for data, 0x03 for statistics request and 0x04 for statistics response. Only 0x03 gets an answer. Framing beyond the type byte is handled elsewhere.

Top module: `link_stats_unit`

## Requirements
- R1: After reset, rx_rdy is 1 and tx_vld is 0. The reported failure count and the delay average are both zero.
- R2: A byte 0x03 accepted on the request stream (rx_vld and rx_rdy high at a clock edge) makes tx_vld rise in the next cycle. Five bytes follow, in this order: 0x04, failure count, queue count, delay average high byte, delay average low byte.
- R3: Any other accepted byte is consumed with no response. This covers 0x01, 0x02 and 0x04 as well as all unknown values. tx_vld stays 0.
- R4: While a response is pending, rx_rdy is 0. Whenever tx_vld is high and tx_rdy is low, tx_vld and tx_data hold their values into the next cycle.
- R5: Each cycle in which any outcome strobe is high counts as one request. The request counts as one failure if att_busy_fail, att_retry_fail or both are high. A cycle with no strobe counts nothing.
- R6: At the 255th request of a window, that window's failure total, including the closing request, becomes the reported count. The window then restarts at zero. The reported count does not change until the next window closes.
- R7: On each cycle with done_vld high, the delay average becomes floor((7·avg + s)/8), where s is the sample. Without done_vld it is unchanged.
- R8: A done_ticks value above 65535 is taken as 65535 before averaging.
- R9: All response fields are captured at the clock edge that accepts the request. Later changes to q_level, the counters or the average do not alter a response already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Host byte valid |
| rx_data | input | 8 | Host byte (message type) |
| rx_rdy | output | 1 | Block can accept a host byte |
| tx_vld | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_rdy | input | 1 | Host accepts response byte |
| att_ok | input | 1 | Request completed successfully |
| att_busy_fail | input | 1 | Request aborted: channel busy at attempt limit |
| att_retry_fail | input | 1 | Request aborted: retransmission limit reached |
| q_level | input | 8 | Packets waiting in the output queue |
| done_vld | input | 1 | Completion-time sample valid |
| done_ticks | input | 20 | Completion time in clock ticks |

## Verification
The bench runs a 255-request window and asks for statistics after 254 requests. A design that closed its window one request early, or reported the running count, would show a nonzero count there. Some requests raise both abort strobes at once. A design that added them separately would report too many failures. Strobe-free gaps check that idle cycles are not counted.

An oversized completion time checks saturation. A design without it would wrap the sample and give a small average. The bench also stalls tx_rdy and changes q_level in the middle of a response. A design that read live values, or let a byte slip under back-pressure, would send a wrong queue byte or lose or duplicate a byte. Configuration, data, response and unknown bytes are all sent to the request stream. A decoder that matched loosely would answer one of them.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [7:0] MSG_CFG   = 8'h01;
  localparam logic [7:0] MSG_DATA  = 8'h02;
  localparam logic [7:0] MSG_STREQ = 8'h03;
  localparam logic [7:0] MSG_STRSP = 8'h04;
endpackage

// File: rtl/lsu_window.sv
module lsu_window #(
  parameter int WIN = 255,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          att_ok,
  input  logic          att_busy_fail,
  input  logic          att_retry_fail,
  output logic [CW-1:0] fail_rpt
);
  logic [CW-1:0] req_cnt, req_cnt_n;
  logic [CW-1:0] fail_cnt, fail_cnt_n;
  logic [CW-1:0] rpt_n;
  logic          req_any, req_bad, win_end;

  assign req_any = att_ok | att_busy_fail | att_retry_fail;
  assign req_bad = att_busy_fail | att_retry_fail;
  assign win_end = req_any && (req_cnt == CW'(WIN - 1));

  always_comb begin
    req_cnt_n  = req_cnt;
    fail_cnt_n = fail_cnt;
    rpt_n      = fail_rpt;
    if (win_end) begin
      rpt_n      = fail_cnt + CW'(req_bad);
      req_cnt_n  = '0;
      fail_cnt_n = '0;
    end else if (req_any) begin
      req_cnt_n  = req_cnt + 1'b1;
      fail_cnt_n = fail_cnt + CW'(req_bad);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt  <= '0;
      fail_cnt <= '0;
      fail_rpt <= '0;
    end else if (req_any) begin
      req_cnt  <= req_cnt_n;
      fail_cnt <= fail_cnt_n;
      fail_rpt <= rpt_n;
    end
  end

  // R6: window position never reaches the window size
  p_win_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt < CW'(WIN));
  // R5: failures in a window never exceed requests in it
  p_fail_le_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_cnt <= req_cnt);
  // R6: closing request restarts the window
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (req_cnt == '0) && (fail_cnt == '0));
  // R5: a cycle with no strobe changes nothing
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |=> $stable(req_cnt) && $stable(fail_cnt) && $stable(fail_rpt));
endmodule

// File: rtl/lsu_ema.sv
module lsu_ema #(
  parameter int MW = 20,
  parameter int DW = 16,
  parameter int SH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_vld,
  input  logic [MW-1:0] done_ticks,
  output logic [DW-1:0] avg
);
  localparam int AW = DW + SH;
  localparam logic [MW-1:0] CAP = MW'({DW{1'b1}});

  logic [DW-1:0] sample;
  logic [AW-1:0] acc;
  logic [DW-1:0] avg_n;

  always_comb begin
    sample = (done_ticks > CAP) ? {DW{1'b1}} : done_ticks[DW-1:0];
    acc    = (AW'(avg) << SH) - AW'(avg) + AW'(sample);
    avg_n  = acc[AW-1:SH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avg <= '0;
    else if (done_vld) avg <= avg_n;
  end

  // R7: average holds without a sample
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_vld |=> $stable(avg));
  // R7, R8: new average lies no higher than the larger of old average and sample
  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |=> (avg <= $past(avg)) || (avg <= $past(sample)));
endmodule

// File: rtl/lsu_resp.sv
module lsu_resp
  import lsu_pkg::*;
#(
  parameter int CW = 8,
  parameter int QW = 8,
  parameter int DW = 16,
  localparam int FW = 8 + CW + QW + DW,
  localparam int NB = FW / 8,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_vld,
  input  logic [7:0]    rx_data,
  output logic          rx_rdy,
  output logic          tx_vld,
  output logic [7:0]    tx_data,
  input  logic          tx_rdy,
  input  logic [CW-1:0] fail_rpt,
  input  logic [QW-1:0] q_level,
  input  logic [DW-1:0] avg
);
  logic          busy, busy_n;
  logic [IW-1:0] idx, idx_n;
  logic [FW-1:0] frame, frame_n;
  logic          take_req, load_en;

  assign rx_rdy   = !busy;
  assign tx_vld   = busy;
  assign tx_data  = frame[FW-1 -: 8];
  assign take_req = !busy && rx_vld && (rx_data == MSG_STREQ);
  assign load_en  = take_req || (busy && tx_rdy);

  always_comb begin
    busy_n  = busy;
    idx_n   = idx;
    frame_n = frame;
    if (take_req) begin
      busy_n  = 1'b1;
      idx_n   = '0;
      frame_n = {MSG_STRSP, fail_rpt, q_level, avg};
    end else if (busy && tx_rdy) begin
      frame_n = frame << 8;
      if (idx == IW'(NB - 1)) busy_n = 1'b0;
      else idx_n = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      frame <= '0;
    end else if (load_en) begin
      busy  <= busy_n;
      idx   <= idx_n;
      frame <= frame_n;
    end
  end

  // R2: accepted request opens a response with the response type
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_rdy && rx_data == MSG_STREQ) |=> tx_vld && (tx_data == MSG_STRSP));
  // R3: any other accepted byte produces nothing
  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_rdy && rx_data != MSG_STREQ) |=> !tx_vld);
  // R4: stalled byte is held
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !tx_rdy) |=> tx_vld && $stable(tx_data));
endmodule

// File: rtl/link_stats_unit.sv
module link_stats_unit #(
  parameter int WIN = 255,
  parameter int QW  = 8,
  parameter int MW  = 20,
  parameter int DW  = 16,
  parameter int SH  = 3,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_vld,
  input  logic [7:0]    rx_data,
  output logic          rx_rdy,
  output logic          tx_vld,
  output logic [7:0]    tx_data,
  input  logic          tx_rdy,
  input  logic          att_ok,
  input  logic          att_busy_fail,
  input  logic          att_retry_fail,
  input  logic [QW-1:0] q_level,
  input  logic          done_vld,
  input  logic [MW-1:0] done_ticks
);
  logic [CW-1:0] fail_rpt;
  logic [DW-1:0] avg;

  lsu_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n),
    .att_ok(att_ok), .att_busy_fail(att_busy_fail), .att_retry_fail(att_retry_fail),
    .fail_rpt(fail_rpt)
  );

  lsu_ema #(.MW(MW), .DW(DW), .SH(SH)) u_ema (
    .clk(clk), .rst_n(rst_n),
    .done_vld(done_vld), .done_ticks(done_ticks), .avg(avg)
  );

  lsu_resp #(.CW(CW), .QW(QW), .DW(DW)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .rx_vld(rx_vld), .rx_data(rx_data), .rx_rdy(rx_rdy),
    .tx_vld(tx_vld), .tx_data(tx_data), .tx_rdy(tx_rdy),
    .fail_rpt(fail_rpt), .q_level(q_level), .avg(avg)
  );

  // R4: no request is taken while a response is pending
  p_noaccept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> !rx_rdy);
endmodule

// File: tb/link_stats_unit_test.sv
module link_stats_unit_test;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_vld = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_rdy, tx_vld;
  logic [7:0] tx_data;
  logic tx_rdy = 1'b1;
  logic att_ok = 1'b0, att_busy_fail = 1'b0, att_retry_fail = 1'b0;
  logic [7:0] q_level = 8'd0;
  logic done_vld = 1'b0;
  logic [19:0] done_ticks = 20'd0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(TCLK/2) clk = ~clk;

  link_stats_unit uut (
    .clk(clk), .rst_n(rst_n),
    .rx_vld(rx_vld), .rx_data(rx_data), .rx_rdy(rx_rdy),
    .tx_vld(tx_vld), .tx_data(tx_data), .tx_rdy(tx_rdy),
    .att_ok(att_ok), .att_busy_fail(att_busy_fail), .att_retry_fail(att_retry_fail),
    .q_level(q_level), .done_vld(done_vld), .done_ticks(done_ticks)
  );

  // behavioural reference model
  int req_m, fcnt_m, rpt_m, avg_m;
  int outq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m = 0; fcnt_m = 0; rpt_m = 0; avg_m = 0;
      outq.delete();
    end else begin
      if (outq.size() != 0) begin
        if (tx_rdy) void'(outq.pop_front());
      end else if (rx_vld && rx_data == 8'h03) begin
        outq.push_back(4);
        outq.push_back(rpt_m);
        outq.push_back(int'(q_level));
        outq.push_back(avg_m / 256);
        outq.push_back(avg_m % 256);
      end
      if (att_ok || att_busy_fail || att_retry_fail) begin
        req_m++;
        if (att_busy_fail || att_retry_fail) fcnt_m++;
        if (req_m == 255) begin
          rpt_m = fcnt_m; req_m = 0; fcnt_m = 0;
        end
      end
      if (done_vld) begin
        int s;
        s = (done_ticks > 20'd65535) ? 65535 : int'(done_ticks);
        avg_m = (avg_m * 7 + s) / 8;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 rx_rdy", int'(rx_rdy), int'(outq.size() == 0));
      check("R2 tx_vld", int'(tx_vld), int'(outq.size() != 0));
      if (tx_vld && outq.size() != 0) check("R2 tx_data", int'(tx_data), outq[0]);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1 rx_vld = 1'b1; rx_data = b;
    @(posedge clk); #1 rx_vld = 1'b0;
  endtask

  task automatic get_resp(input bit slow, input int qchg, output int got [5]);
    int n = 0;
    int cyc = 0;
    tx_rdy = !slow;
    send_byte(8'h03);
    while (n < 5 && cyc < 200) begin
      @(negedge clk);
      if (tx_vld && tx_rdy) begin got[n] = int'(tx_data); n++; end
      @(posedge clk); #1;
      if (qchg >= 0) q_level = 8'(qchg);
      if (slow) tx_rdy = (cyc % 3 == 2);
      cyc++;
    end
    tx_rdy = 1'b1;
    check("R2 byte count", n, 5);
  endtask

  task automatic strobe(input bit ok, input bit bf, input bit rf);
    @(posedge clk); #1 att_ok = ok; att_busy_fail = bf; att_retry_fail = rf;
  endtask

  task automatic strobe_off();
    @(posedge clk); #1 att_ok = 1'b0; att_busy_fail = 1'b0; att_retry_fail = 1'b0;
  endtask

  task automatic sample(input int t);
    @(posedge clk); #1 done_vld = 1'b1; done_ticks = 20'(t);
    @(posedge clk); #1 done_vld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r [5];
    int nf;
    q_level = 8'd7;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rx_rdy after reset", int'(rx_rdy), 1);
    check("R1 tx_vld after reset", int'(tx_vld), 0);

    get_resp(1'b0, -1, r);
    check("R2 type byte", r[0], 4);
    check("R1 fail count zero", r[1], 0);
    check("R2 queue byte", r[2], 7);
    check("R1 delay zero", r[3] * 256 + r[4], 0);

    // R3: non-request bytes
    foreach (r[i]) r[i] = 0;
    begin
      logic [7:0] others [6] = '{8'h01, 8'h02, 8'h04, 8'hFF, 8'h00, 8'h83};
      foreach (others[i]) begin
        send_byte(others[i]);
        @(negedge clk);
        check("R3 no response", int'(tx_vld), 0);
        check("R3 still ready", int'(rx_rdy), 1);
      end
    end

    // R7, R8: averaging and saturation
    sample(800);
    get_resp(1'b0, -1, r);
    check("R7 delay after 800", r[3] * 256 + r[4], 100);
    sample(20'h12345);
    get_resp(1'b0, -1, r);
    check("R8 saturated average", r[3] * 256 + r[4], 8279);
    repeat (2) @(posedge clk);
    get_resp(1'b0, -1, r);
    check("R7 holds without sample", r[3] * 256 + r[4], 8279);

    // R5, R6: first window
    nf = 0;
    for (int i = 0; i < 254; i++) begin
      bit bf = (i % 5 == 0);
      bit rf = (i % 7 == 0);
      if (bf || rf) nf++;
      strobe(!(bf || rf), bf, rf);
      if (i % 50 == 49) strobe_off();
    end
    strobe_off();
    get_resp(1'b0, -1, r);
    check("R6 count before window closes", r[1], 0);
    strobe(1'b0, 1'b1, 1'b1);
    nf++;
    strobe_off();
    get_resp(1'b0, -1, r);
    check("R5 R6 latched window failures", r[1], nf);

    // R6: second window, value held mid-window
    for (int i = 0; i < 100; i++) strobe(i >= 3, i < 3, 1'b0);
    strobe_off();
    get_resp(1'b0, -1, r);
    check("R6 report held mid-window", r[1], nf);
    for (int i = 0; i < 155; i++) strobe(1'b1, 1'b0, 1'b0);
    strobe_off();
    get_resp(1'b0, -1, r);
    check("R6 second window count", r[1], 3);

    // R4, R9: back-pressure and snapshot
    q_level = 8'd9;
    get_resp(1'b1, 200, r);
    check("R9 queue snapshot", r[2], 9);
    check("R4 type under stall", r[0], 4);
    check("R9 fail snapshot", r[1], 3);
    check("R9 delay snapshot", r[3] * 256 + r[4], 8279);

    // R4: request held during busy is not taken twice
    tx_rdy = 1'b0;
    @(posedge clk); #1 rx_vld = 1'b1; rx_data = 8'h03;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R4 busy blocks input", int'(rx_rdy), 0);
    rx_vld = 1'b0;
    tx_rdy = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R4 single response", int'(tx_vld), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule